// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a 32-bit processor that shares a single memory and a single ALU across the steps of an instruction. It reads the 6-bit opcode held in the instruction register. Each cycle it drives the strobes and selects that steer the datapath. Every instruction starts with a fetch step and then a decode step. After that the path depends on the instruction class, through address, execute, memory and write-back steps. Control then returns to fetch.

The outputs are Moore outputs: they depend only on the current state. A change in the opcode has effect only at the clock edges that leave the decode step and the address step. A jump or a branch takes three cycles. An R-type or a store takes four cycles. A load takes five cycles. An opcode that the block does not recognise leaves decode and goes straight back to fetch.

Top module: `mc_ctrl_top`

## Requirements
- R1: A synchronous reset, asserted high at any step, puts the block in the fetch step at the next clock edge.
- R2: The fetch step drives memRd=1, irLoad=1, pcLoad=1 and aluBSel=01. It drives addrSel=0, aluASel=0, pcSrc=00 and aluClass=00. Every output a step does not name is 0, in every step.
- R3: Fetch is always followed by decode, for any opcode. Decode drives aluBSel=11 and all other outputs 0.
- R4: For a load (opcode 100011) or a store (opcode 101011), decode is followed by an address step that drives aluASel=1, aluBSel=10 and aluClass=00.
- R5: For a load, the address step is followed by a read step (addrSel=1, memRd=1). That is followed by a write-back step (memToReg=1, regWr=1, regDst=0). Fetch comes next, so a load takes 5 cycles.
- R6: For a store, the address step is followed by a write step (addrSel=1, memWr=1). Fetch comes next, so a store takes 4 cycles.
- R7: For an R-type (opcode 000000), decode is followed by an execute step (aluASel=1, aluBSel=00, aluClass=10). That is followed by a completion step (regDst=1, regWr=1, memToReg=0). Fetch comes next, so an R-type takes 4 cycles.
- R8: For a branch-equal (opcode 000100), decode is followed by one step with aluASel=1, aluBSel=00, aluClass=01, pcSrc=01 and pcLoadIfZero=1. Fetch comes next, so a branch takes 3 cycles.
- R9: For a jump (opcode 000010), decode is followed by one step with pcSrc=10 and pcLoad=1. Fetch comes next, so a jump takes 3 cycles.
- R10: Any other opcode goes from decode straight back to fetch. No step of that instruction asserts regWr, memWr or pcLoadIfZero.
- R11: memRd and memWr are never both 1. regWr and memWr are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| addrSel | output | 1 | Memory address source: 0 selects PC, 1 selects ALU result register |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| irLoad | output | 1 | Instruction register load |
| memToReg | output | 1 | Register write data source: 1 selects memory data register |
| regDst | output | 1 | Destination register field: 1 selects rd, 0 selects rt |
| regWr | output | 1 | Register file write strobe |
| pcLoad | output | 1 | Unconditional PC write |
| pcLoadIfZero | output | 1 | PC write qualified by ALU zero |
| pcSrc | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| aluASel | output | 1 | ALU A input: 0 PC, 1 register A |
| aluBSel | output | 2 | ALU B input: 00 register B, 01 constant 4, 10 offset, 11 shifted offset |
| aluClass | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |

## Verification
A wrong state shows up at the ports in the very next cycle, because each step has its own output vector. The one exception is decode, which every instruction visits: its vector is the same for every opcode. A wrong branch taken out of decode therefore first shows up one cycle later, in the execute or address step. A wrong branch out of the address step shows up in the memory step that follows it. A wrong return to fetch shows up as a missing or extra fetch vector, which changes the instruction length in cycles. The bench keeps its own step sequence for each opcode and compares the full output vector in every cycle. This covers random opcodes, unrecognised opcodes, and resets in the middle of an instruction.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int OP_W  = 6;
  localparam int SEL_W = 2;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;

  typedef enum logic [2:0] {
    CL_RTYPE, CL_LOAD, CL_STORE, CL_BEQ, CL_JUMP, CL_OTHER
  } opClass_t;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_MEMRD, ST_MEMWR,
    ST_WBACK, ST_REXEC, ST_RDONE, ST_BRANCH, ST_JUMP
  } step_t;

  typedef struct packed {
    logic             addrSel;
    logic             memRd;
    logic             memWr;
    logic             irLoad;
    logic             memToReg;
    logic             regDst;
    logic             regWr;
    logic             pcLoad;
    logic             pcLoadIfZero;
    logic [SEL_W-1:0] pcSrc;
    logic             aluASel;
    logic [SEL_W-1:0] aluBSel;
    logic [SEL_W-1:0] aluClass;
  } strobes_t;

  function automatic opClass_t classify(input logic [OP_W-1:0] op);
    case (op)
      OP_RTYPE: return CL_RTYPE;
      OP_LOAD:  return CL_LOAD;
      OP_STORE: return CL_STORE;
      OP_BEQ:   return CL_BEQ;
      OP_JUMP:  return CL_JUMP;
      default:  return CL_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/mc_seq.sv
module mc_seq
  import mc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output step_t           step
);
  step_t    nxt;
  opClass_t cls;

  assign cls = classify(opcode);

  always_comb begin
    nxt = ST_FETCH;
    case (step)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          CL_LOAD, CL_STORE: nxt = ST_ADDR;
          CL_RTYPE:          nxt = ST_REXEC;
          CL_BEQ:            nxt = ST_BRANCH;
          CL_JUMP:           nxt = ST_JUMP;
          default:           nxt = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        if (cls == CL_LOAD)       nxt = ST_MEMRD;
        else if (cls == CL_STORE) nxt = ST_MEMWR;
        else                      nxt = ST_FETCH;
      end
      ST_MEMRD:  nxt = ST_WBACK;
      ST_REXEC:  nxt = ST_RDONE;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_FETCH;
    else     step <= nxt;
  end
endmodule

// File: rtl/mc_strobe.sv
module mc_strobe
  import mc_pkg::*;
(
  input  step_t    step,
  output strobes_t ctl
);
  always_comb begin
    ctl = '0;
    case (step)
      ST_FETCH: begin
        ctl.memRd   = 1'b1;
        ctl.irLoad  = 1'b1;
        ctl.pcLoad  = 1'b1;
        ctl.aluBSel = 2'b01;
      end
      ST_DECODE: ctl.aluBSel = 2'b11;
      ST_ADDR: begin
        ctl.aluASel = 1'b1;
        ctl.aluBSel = 2'b10;
      end
      ST_MEMRD: begin
        ctl.addrSel = 1'b1;
        ctl.memRd   = 1'b1;
      end
      ST_MEMWR: begin
        ctl.addrSel = 1'b1;
        ctl.memWr   = 1'b1;
      end
      ST_WBACK: begin
        ctl.memToReg = 1'b1;
        ctl.regWr    = 1'b1;
      end
      ST_REXEC: begin
        ctl.aluASel  = 1'b1;
        ctl.aluClass = 2'b10;
      end
      ST_RDONE: begin
        ctl.regDst = 1'b1;
        ctl.regWr  = 1'b1;
      end
      ST_BRANCH: begin
        ctl.aluASel      = 1'b1;
        ctl.aluClass     = 2'b01;
        ctl.pcSrc        = 2'b01;
        ctl.pcLoadIfZero = 1'b1;
      end
      ST_JUMP: begin
        ctl.pcSrc  = 2'b10;
        ctl.pcLoad = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_top.sv
module mc_ctrl_top
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  output logic             addrSel,
  output logic             memRd,
  output logic             memWr,
  output logic             irLoad,
  output logic             memToReg,
  output logic             regDst,
  output logic             regWr,
  output logic             pcLoad,
  output logic             pcLoadIfZero,
  output logic [SEL_W-1:0] pcSrc,
  output logic             aluASel,
  output logic [SEL_W-1:0] aluBSel,
  output logic [SEL_W-1:0] aluClass
);
  step_t    step;
  strobes_t ctl;

  mc_seq u_seq (.clk(clk), .rst(rst), .opcode(opcode), .step(step));
  mc_strobe u_strobe (.step(step), .ctl(ctl));

  assign addrSel      = ctl.addrSel;
  assign memRd        = ctl.memRd;
  assign memWr        = ctl.memWr;
  assign irLoad       = ctl.irLoad;
  assign memToReg     = ctl.memToReg;
  assign regDst       = ctl.regDst;
  assign regWr        = ctl.regWr;
  assign pcLoad       = ctl.pcLoad;
  assign pcLoadIfZero = ctl.pcLoadIfZero;
  assign pcSrc        = ctl.pcSrc;
  assign aluASel      = ctl.aluASel;
  assign aluBSel      = ctl.aluBSel;
  assign aluClass     = ctl.aluClass;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       addrSel,
  input logic       memRd,
  input logic       memWr,
  input logic       irLoad,
  input logic       memToReg,
  input logic       regWr,
  input logic       pcLoad,
  input logic       pcLoadIfZero,
  input logic [1:0] pcSrc,
  input logic [1:0] aluBSel
);
  a_r1_reset_fetch: assert property (@(posedge clk)
    rst |=> (irLoad && pcLoad && memRd));

  a_r3_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    irLoad |=> (aluBSel == 2'b11 && !irLoad && !regWr && !memWr && !pcLoad));

  a_r5_read_then_wback: assert property (@(posedge clk) disable iff (rst)
    (memRd && addrSel) |=> (memToReg && regWr));

  a_r6_store_returns: assert property (@(posedge clk) disable iff (rst)
    memWr |=> irLoad);

  a_r8_branch_returns: assert property (@(posedge clk) disable iff (rst)
    pcLoadIfZero |=> irLoad);

  a_r9_jump_returns: assert property (@(posedge clk) disable iff (rst)
    (pcLoad && pcSrc == 2'b10) |=> irLoad);

  a_r11_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(memRd && memWr) && !(regWr && memWr));
endmodule

bind mc_ctrl_top mc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .addrSel(addrSel), .memRd(memRd), .memWr(memWr),
  .irLoad(irLoad), .memToReg(memToReg), .regWr(regWr), .pcLoad(pcLoad),
  .pcLoadIfZero(pcLoadIfZero), .pcSrc(pcSrc), .aluBSel(aluBSel)
);

// File: tb/tb_mc_ctrl_top.sv
module tb_mc_ctrl_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       addrSel, memRd, memWr, irLoad, memToReg, regDst, regWr;
  logic       pcLoad, pcLoadIfZero, aluASel;
  logic [1:0] pcSrc, aluBSel, aluClass;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_ctrl_top dut (
    .clk(clk), .rst(rst), .opcode(opcode), .addrSel(addrSel), .memRd(memRd),
    .memWr(memWr), .irLoad(irLoad), .memToReg(memToReg), .regDst(regDst),
    .regWr(regWr), .pcLoad(pcLoad), .pcLoadIfZero(pcLoadIfZero),
    .pcSrc(pcSrc), .aluASel(aluASel), .aluBSel(aluBSel), .aluClass(aluClass)
  );

  // step codes: 0 fetch 1 decode 2 addr 3 read 4 write 5 wback
  //             6 rexec 7 rdone 8 branch 9 jump
  // vector {addrSel,memRd,memWr,irLoad,memToReg,regDst,regWr,pcLoad,
  //         pcLoadIfZero,pcSrc[1:0],aluASel,aluBSel[1:0],aluClass[1:0]}
  function automatic logic [15:0] expVec(input int s);
    logic a = 0, mr = 0, mw = 0, ir = 0, m2r = 0, dst = 0, rw = 0, pl = 0, pz = 0, as = 0;
    logic [1:0] ps = 0, bs = 0, ac = 0;
    case (s)
      0: begin mr = 1; ir = 1; pl = 1; bs = 2'b01; end
      1: bs = 2'b11;
      2: begin as = 1; bs = 2'b10; end
      3: begin a = 1; mr = 1; end
      4: begin a = 1; mw = 1; end
      5: begin m2r = 1; rw = 1; end
      6: begin as = 1; ac = 2'b10; end
      7: begin dst = 1; rw = 1; end
      8: begin as = 1; ac = 2'b01; ps = 2'b01; pz = 1; end
      9: begin ps = 2'b10; pl = 1; end
      default: ;
    endcase
    return {a, mr, mw, ir, m2r, dst, rw, pl, pz, ps, as, bs, ac};
  endfunction

  function automatic int instLen(input logic [5:0] op);
    case (op)
      6'b100011: return 5;
      6'b101011: return 4;
      6'b000000: return 4;
      6'b000100: return 3;
      6'b000010: return 3;
      default:   return 2;
    endcase
  endfunction

  function automatic int stepAt(input logic [5:0] op, input int k);
    if (k == 0) return 0;
    if (k == 1) return 1;
    case (op)
      6'b100011: return (k == 2) ? 2 : (k == 3) ? 3 : 5;
      6'b101011: return (k == 2) ? 2 : 4;
      6'b000000: return (k == 2) ? 6 : 7;
      6'b000100: return 8;
      default:   return 9;
    endcase
  endfunction

  function automatic string tagOf(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 5: return "R5";
      4: return "R6";
      6, 7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [15:0] actVec();
    return {addrSel, memRd, memWr, irLoad, memToReg, regDst, regWr, pcLoad,
            pcLoadIfZero, pcSrc, aluASel, aluBSel, aluClass};
  endfunction

  task automatic checkVec(input logic [15:0] exp, input string tag);
    checks++;
    if (actVec() !== exp) begin
      errors++;
      $display("FAIL %s: vector actual=%b expected=%b (opcode=%b)", tag, actVec(), exp, opcode);
    end
    checks++;
    if ((memRd && memWr) || (regWr && memWr)) begin
      errors++;
      $display("FAIL R11: memRd/memWr/regWr actual=%b%b%b expected no memWr overlap",
               memRd, memWr, regWr);
    end
  endtask

  task automatic runInst(input logic [5:0] op, input bit afterUnknown);
    opcode = op;
    for (int k = 0; k < instLen(op); k++) begin
      int s = stepAt(op, k);
      string tag = tagOf(s);
      if (k == 0 && afterUnknown) tag = "R10";
      if (instLen(op) == 2 && k == 1) tag = "R10";
      checkVec(expVec(s), tag);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [5];
    bit prevUnknown = 0;
    ops[0] = 6'b000000; ops[1] = 6'b100011; ops[2] = 6'b101011;
    ops[3] = 6'b000100; ops[4] = 6'b000010;
    void'($urandom(32'h1234_5EED));

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checkVec(expVec(0), "R1");

    // directed: each class once, then unknown opcodes
    for (int i = 0; i < 5; i++) runInst(ops[i], 0);
    runInst(6'b111111, 0);
    runInst(6'b100011, 1);
    runInst(6'b000001, 0);
    runInst(6'b000000, 1);

    // R1: reset in the middle of a load (address step) and of an R-type (decode)
    opcode = 6'b100011;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkVec(expVec(2), "R4");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checkVec(expVec(0), "R1");
    opcode = 6'b000000;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checkVec(expVec(0), "R1");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] op;
      if ($urandom_range(0, 3) == 0) op = 6'($urandom);
      else op = ops[$urandom_range(0, 4)];
      runInst(op, prevUnknown);
      prevUnknown = (instLen(op) == 2);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule